// File: doc/BRIEF.md
# DMA Event Interrupt Controller

This block collects event pulses from a six-channel DMA engine into two status registers, one for normal events and one for error events. Each status register has a mask register beside it, and a single level interrupt line is raised while any status bit is set whose mask bit is clear. Hardware sets status bits with one-cycle pulses. Software clears a status bit by writing a one to it.

Software never writes a mask register directly. It clears mask bits through an enable alias address and sets them through a disable alias address. The register port is a plain 32-bit word-addressed write strobe with a combinational read path. The interrupt output is registered.

Register word addresses: 0 normal status, 1 normal mask, 2 normal enable alias, 3 normal disable alias, 4 error status, 5 error mask, 6 error enable alias, 7 error disable alias.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset both status registers read 0, the normal mask reads 0x07FFFFFF, the error mask reads 0xFFFFFFFF and the interrupt output is low.
- R2: A write to a status address (0 or 4) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R3: In the normal status register, channel c descriptor-done sets bit c, channel c data-fetch error sets bit 12+c, and the frame sync pulse sets bit 27.
- R4: In the error status register, channel c sets bit 1+c for a descriptor-fetch failure, bit 7+c for a bad preamble, bit 13+c for a checksum mismatch and bit 25+c for a descriptor already marked done.
- R5: A write to an enable alias (2 or 6) clears the mask bits written as 1; a write to a disable alias (3 or 7) sets them; bits written as 0 keep their value.
- R6: Writes to a mask address (1 or 5) have no effect on the mask.
- R7: The interrupt output is high exactly when some status bit is set with its mask bit clear, in either register pair.
- R8: When a set pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: The interrupt output follows a change of status or mask one clock cycle after the register changes.
- R10: Reading an enable or disable alias address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| ev_desc_done | input | 6 | Per-channel descriptor completed pulse |
| ev_data_err | input | 6 | Per-channel payload fetch error pulse |
| ev_frame_sync | input | 1 | Frame sync event pulse |
| ev_fetch_fail | input | 6 | Per-channel descriptor fetch failure pulse |
| ev_bad_preamble | input | 6 | Per-channel invalid preamble pulse |
| ev_bad_sum | input | 6 | Per-channel checksum mismatch pulse |
| ev_redone | input | 6 | Per-channel already-done descriptor pulse |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: six channels and 32-bit registers. With six channels the highest per-channel bits sit at 17 in the normal register and 30 in the error register, so driving channel 5 reaches the top of every field. The frame sync bit 27 is unmasked at reset, which lets the bench measure the one-cycle interrupt latency without first enabling anything.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int unsigned REG_W = 32;

    // normal register bit layout
    localparam int unsigned NRM_DONE_LSB  = 0;
    localparam int unsigned NRM_DERR_LSB  = 12;
    localparam int unsigned NRM_SYNC_BIT  = 27;

    // error register bit layout
    localparam int unsigned ERR_FETCH_LSB = 1;
    localparam int unsigned ERR_PRE_LSB   = 7;
    localparam int unsigned ERR_SUM_LSB   = 13;
    localparam int unsigned ERR_REDO_LSB  = 25;

    localparam logic [REG_W-1:0] NRM_MASK_RST = 32'h07FF_FFFF;
    localparam logic [REG_W-1:0] ERR_MASK_RST = 32'hFFFF_FFFF;

    // offset of a register within one bank (addr low bits)
    typedef enum logic [1:0] {
        SLOT_STAT = 2'd0,
        SLOT_MASK = 2'd1,
        SLOT_EN   = 2'd2,
        SLOT_DIS  = 2'd3
    } bank_slot_e;

endpackage

// File: rtl/irq_event_map.sv
module irq_event_map
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NUM_CH = 6,
    parameter int unsigned W      = REG_W
) (
    input  logic [NUM_CH-1:0] desc_done_i,
    input  logic [NUM_CH-1:0] data_err_i,
    input  logic              frame_sync_i,
    input  logic [NUM_CH-1:0] fetch_fail_i,
    input  logic [NUM_CH-1:0] bad_pre_i,
    input  logic [NUM_CH-1:0] bad_sum_i,
    input  logic [NUM_CH-1:0] redone_i,
    output logic [W-1:0]      nrm_set_o,
    output logic [W-1:0]      err_set_o
);

    always_comb begin
        nrm_set_o = '0;
        err_set_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            nrm_set_o[NRM_DONE_LSB  + c] = desc_done_i[c];
            nrm_set_o[NRM_DERR_LSB  + c] = data_err_i[c];
            err_set_o[ERR_FETCH_LSB + c] = fetch_fail_i[c];
            err_set_o[ERR_PRE_LSB   + c] = bad_pre_i[c];
            err_set_o[ERR_SUM_LSB   + c] = bad_sum_i[c];
            err_set_o[ERR_REDO_LSB  + c] = redone_i[c];
        end
        nrm_set_o[NRM_SYNC_BIT] = frame_sync_i;
    end

endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
    parameter int unsigned     W        = 32,
    parameter logic [W-1:0]    MASK_RST = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] dis_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] mask_o,
    output logic         pend_o
);

    typedef struct packed {
        logic [W-1:0] status;
        logic [W-1:0] mask;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d        = bank_q;
        // set after clear: a pulse beats a same-cycle clear
        bank_d.status = (bank_q.status & ~clr_i) | set_i;
        bank_d.mask   = (bank_q.mask & ~en_i) | dis_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q.status <= '0;
            bank_q.mask   <= MASK_RST;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign status_o = bank_q.status;
    assign mask_o   = bank_q.mask;
    assign pend_o   = |(bank_q.status & ~bank_q.mask);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & $past(set_i)) == $past(set_i))) else $error("set lost"); // R8

    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & $past(clr_i & ~set_i)) == '0)) else $error("clear lost"); // R2

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == '0 && dis_i == '0) |=> $stable(mask_o)) else $error("mask moved"); // R6

    AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i != '0) |=> ((mask_o & $past(en_i)) == '0)) else $error("enable failed"); // R5

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NUM_CH = 6,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic [NUM_CH-1:0] ev_desc_done,
    input  logic [NUM_CH-1:0] ev_data_err,
    input  logic              ev_frame_sync,
    input  logic [NUM_CH-1:0] ev_fetch_fail,
    input  logic [NUM_CH-1:0] ev_bad_preamble,
    input  logic [NUM_CH-1:0] ev_bad_sum,
    input  logic [NUM_CH-1:0] ev_redone,
    output logic              irq
);

    localparam int unsigned NUM_BANK = 2;
    localparam int unsigned BANK_BIT = ADDR_W - 1;

    typedef struct packed {
        logic irq;
    } top_t;

    logic [REG_W-1:0] set_v  [NUM_BANK];
    logic [REG_W-1:0] stat_v [NUM_BANK];
    logic [REG_W-1:0] mask_v [NUM_BANK];
    logic             pend_v [NUM_BANK];
    bank_slot_e       slot;
    top_t             top_d, top_q;

    assign slot = bank_slot_e'(addr[1:0]);

    irq_event_map #(.NUM_CH(NUM_CH), .W(REG_W)) u_map (
        .desc_done_i  (ev_desc_done),
        .data_err_i   (ev_data_err),
        .frame_sync_i (ev_frame_sync),
        .fetch_fail_i (ev_fetch_fail),
        .bad_pre_i    (ev_bad_preamble),
        .bad_sum_i    (ev_bad_sum),
        .redone_i     (ev_redone),
        .nrm_set_o    (set_v[0]),
        .err_set_o    (set_v[1])
    );

    for (genvar g = 0; g < NUM_BANK; g++) begin : g_bank
        localparam logic [REG_W-1:0] RST_M = (g == 0) ? NRM_MASK_RST : ERR_MASK_RST;
        logic             hit;
        logic [REG_W-1:0] clr, en, dis;

        always_comb begin
            hit = wr_en && (addr[BANK_BIT] == 1'(g));
            clr = (hit && slot == SLOT_STAT) ? wdata : '0;
            en  = (hit && slot == SLOT_EN)   ? wdata : '0;
            dis = (hit && slot == SLOT_DIS)  ? wdata : '0;
        end

        irq_bank #(.W(REG_W), .MASK_RST(RST_M)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (set_v[g]),
            .clr_i    (clr),
            .en_i     (en),
            .dis_i    (dis),
            .status_o (stat_v[g]),
            .mask_o   (mask_v[g]),
            .pend_o   (pend_v[g])
        );
    end

    always_comb begin
        top_d     = top_q;
        top_d.irq = pend_v[0] | pend_v[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    always_comb begin
        unique case (slot)
            SLOT_STAT: rdata = stat_v[addr[BANK_BIT]];
            SLOT_MASK: rdata = mask_v[addr[BANK_BIT]];
            default:   rdata = '0;
        endcase
    end

    assign irq = top_q.irq;

    AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|((stat_v[0] & ~mask_v[0]) | (stat_v[1] & ~mask_v[1])))))
        else $error("irq mismatch"); // R9

endmodule

// File: tb/tb_dma_irq_ctrl.sv
`timescale 1ns/1ps
module tb_dma_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [5:0]  ev_desc_done = '0, ev_data_err = '0, ev_fetch_fail = '0;
    logic [5:0]  ev_bad_preamble = '0, ev_bad_sum = '0, ev_redone = '0;
    logic        ev_frame_sync = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    dma_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ev_desc_done(ev_desc_done), .ev_data_err(ev_data_err),
        .ev_frame_sync(ev_frame_sync), .ev_fetch_fail(ev_fetch_fail),
        .ev_bad_preamble(ev_bad_preamble), .ev_bad_sum(ev_bad_sum),
        .ev_redone(ev_redone), .irq(irq)
    );

    // monitor: pops expected items and compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {31'b0, irq} : rdata;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic pulse(input logic [5:0] dn, input logic [5:0] de, input logic fs,
                         input logic [5:0] ff, input logic [5:0] pr,
                         input logic [5:0] su, input logic [5:0] rd);
        @(posedge clk); #1;
        ev_desc_done = dn; ev_data_err = de; ev_frame_sync = fs;
        ev_fetch_fail = ff; ev_bad_preamble = pr; ev_bad_sum = su; ev_redone = rd;
        @(posedge clk); #1;
        ev_desc_done = '0; ev_data_err = '0; ev_frame_sync = 1'b0;
        ev_fetch_fail = '0; ev_bad_preamble = '0; ev_bad_sum = '0; ev_redone = '0;
    endtask

    task automatic chk_reg(input logic [2:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        addr = a;
        sb_q.push_back('{1'b0, e, tag});
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(posedge clk); #1;
        sb_q.push_back('{1'b1, {31'b0, e}, tag});
    endtask

    task automatic chk_irq_now(input logic e, input string tag);
        sb_q.push_back('{1'b1, {31'b0, e}, tag});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        chk_reg(3'd0, 32'h0, "R1 normal status");
        chk_reg(3'd1, 32'h07FF_FFFF, "R1 normal mask");
        chk_reg(3'd4, 32'h0, "R1 error status");
        chk_reg(3'd5, 32'hFFFF_FFFF, "R1 error mask");
        chk_irq(1'b0, "R1 irq");

        pulse(6'b000100, 0, 0, 0, 0, 0, 0);
        chk_reg(3'd0, 32'h4, "R3 done ch2 bit2");
        chk_irq(1'b0, "R7 masked stays low");

        wr(3'd2, 32'h4);
        chk_reg(3'd1, 32'h07FF_FFFB, "R5 enable alias");
        chk_irq(1'b1, "R7 unmasked raises");

        wr(3'd0, 32'h0);
        chk_reg(3'd0, 32'h4, "R2 zero write keeps");
        wr(3'd0, 32'h4);
        chk_reg(3'd0, 32'h0, "R2 one write clears");
        chk_irq(1'b0, "R7 cleared drops");

        wr(3'd1, 32'h0);
        chk_reg(3'd1, 32'h07FF_FFFB, "R6 normal mask write ignored");
        wr(3'd5, 32'h0);
        chk_reg(3'd5, 32'hFFFF_FFFF, "R6 error mask write ignored");

        wr(3'd3, 32'h4);
        chk_reg(3'd1, 32'h07FF_FFFF, "R5 disable alias");

        pulse(0, 6'b100000, 0, 0, 0, 0, 0);
        chk_reg(3'd0, 32'h0002_0000, "R3 data err ch5 bit17");
        chk_irq(1'b0, "R7 masked data err");

        pulse(0, 0, 1'b1, 0, 0, 0, 0);
        chk_irq_now(1'b0, "R9 irq not yet");
        chk_irq(1'b1, "R9 irq one cycle later");
        chk_reg(3'd0, 32'h0802_0000, "R3 frame sync bit27");
        wr(3'd0, 32'hFFFF_FFFF);
        chk_irq(1'b0, "R9 irq after clear");

        pulse(0, 0, 0, 6'b000001, 6'b100000, 6'b001000, 6'b100000);
        chk_reg(3'd4, 32'h4001_1002, "R4 error bit layout");
        chk_irq(1'b0, "R7 errors masked");
        wr(3'd6, 32'h4000_0000);
        chk_reg(3'd5, 32'hBFFF_FFFF, "R5 error enable alias");
        chk_irq(1'b1, "R7 error raises");
        wr(3'd4, 32'h4000_0000);
        chk_reg(3'd4, 32'h0001_1002, "R2 error clear one bit");
        chk_irq(1'b0, "R7 error dropped");
        wr(3'd4, 32'hFFFF_FFFF);

        @(posedge clk); #1;
        wr_en = 1'b1; addr = 3'd0; wdata = 32'h1; ev_desc_done = 6'b000001;
        @(posedge clk); #1;
        wr_en = 1'b0; wdata = '0; ev_desc_done = '0;
        chk_reg(3'd0, 32'h1, "R8 set wins over clear");
        wr(3'd0, 32'h1);

        chk_reg(3'd2, 32'h0, "R10 alias read");
        chk_reg(3'd3, 32'h0, "R10 alias read");
        chk_reg(3'd6, 32'h0, "R10 alias read");
        chk_reg(3'd7, 32'h0, "R10 alias read");

        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule